// File: doc/BRIEF.md
# Tick-Paced Serial Byte Transmitter

This block serialises bytes from an upstream first-word-fall-through FIFO onto one asynchronous line in the 8N1 format: a low start bit, eight data bits with the least significant bit first, and a high stop bit. It does not have its own baud-rate generator. It shares a tick strobe that runs at three times the bit rate with other serial logic and divides it by three on its own. Each bit therefore lasts exactly three tick pulses, however irregular the spacing of those pulses in clock cycles.

The FIFO is polled and never pushed. In the idle state the line is held high. At a bit boundary where the FIFO reports data, the block sends a start bit. The byte is read only at the next bit boundary, in the first data-bit slot. If the FIFO has emptied by then, the frame is dropped and the line returns high.

After the stop bit, the state machine spends one more bit period in an end state before it returns to idle. One further idle period then passes before the next start bit can follow. Back-to-back frames therefore start 12 bit periods apart. The state numbering is idle 0, start 1, data bits 2 to 9, stop 10 and end 11, so it matches a companion receiver.

Top module: `tick_uart_tx`

## Requirements
- R1: A bit period lasts exactly 3 `tickEn` pulses. A tick counter that is zeroed by reset marks a bit boundary on every third pulse, however many idle clocks lie between the pulses.
- R2: In the idle state `serOut` is 1. At a bit boundary in idle, the block moves to the start state when `fifoEmpty` is 0 and stays idle when it is 1.
- R3: On the boundary that leaves the start state, `serOut` goes to 0 and stays there for one bit period.
- R4: On the boundary in the first data-bit slot, with `fifoEmpty` at 0, `fifoRd` is high for that single clock cycle and `fifoData` is captured in the same cycle. If `fifoEmpty` is 1 at that boundary, no read is issued, `serOut` returns to 1, and the block goes back to idle.
- R5: The captured byte goes out with bit 0 first, one bit per bit period, as the data bits of the frame.
- R6: After data bit 7, `serOut` is 1 for the stop period, then for an end-state period, then for one idle period. With the FIFO kept non-empty, consecutive start bits begin 12 bit periods apart.
- R7: `serOut` changes only on a clock edge at which `tickEn` was high. While `tickEn` stays low, the frame does not advance.
- R8: While `rstN` is low, `serOut` is 1 and `fifoRd` is 0. A reset in the middle of a frame abandons it.
- R9: `fifoRd` is never asserted while `fifoEmpty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Shared strobe at three times the bit rate, one clock wide per pulse |
| fifoEmpty | input | 1 | High while the source FIFO holds no byte |
| fifoData | input | 8 | Head byte of the source FIFO, valid while `fifoEmpty` is low |
| fifoRd | output | 1 | One-cycle pop strobe to the source FIFO |
| serOut | output | 1 | Registered serial line, idles high |

## Verification
`fifoRd` is combinational. It is due in the same cycle as the third tick of the data-bit-0 period. `serOut` is registered and takes its new level one clock after the tick that closes a bit period. The bench drives its inputs on the falling edge. It compares both outputs one time unit later with a behavioural model that it advances on each rising edge, so the read strobe is checked against the tick it belongs to and the line level is checked against the edge just past. Frame-level checks are taken from a cycle log at mid-bit offsets counted from the first sampled start-bit low.

// File: rtl/tick_uart_tx_pkg.sv
package tick_uart_tx_pkg;

  // Strobes from the frame controller to the line datapath
  typedef struct packed {
    logic loadByte;   // capture FIFO byte, drive its bit 0
    logic shiftBit;   // drive next stored bit, shift right
    logic forceLow;   // start bit
    logic forceHigh;  // idle, stop, abort
  } txCtrl_t;

endpackage

// File: rtl/tx_bit_divider.sv
module tx_bit_divider #(
  parameter int TICKS_PER_BIT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  output logic bitStb
);
  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TICKS_PER_BIT - 1);

  logic [CNT_W-1:0] tickCnt;

  assign bitStb = tickEn && (tickCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (tickEn) begin
      if (tickCnt == LAST_CNT) tickCnt <= '0;
      else                     tickCnt <= tickCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tx_frame_ctrl.sv
module tx_frame_ctrl
  import tick_uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int STATE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitStb,
  input  logic               fifoEmpty,
  output logic               fifoRd,
  output logic [STATE_W-1:0] txState,
  output txCtrl_t            ctrl
);
  localparam logic [STATE_W-1:0] ST_IDLE  = '0;
  localparam logic [STATE_W-1:0] ST_START = STATE_W'(1);
  localparam logic [STATE_W-1:0] ST_FIRST = STATE_W'(2);
  localparam logic [STATE_W-1:0] ST_STOP  = STATE_W'(DATA_W + 2);

  logic [STATE_W-1:0] nextState;

  always_comb begin
    nextState = txState;
    ctrl      = '0;
    fifoRd    = 1'b0;
    if (bitStb) begin
      if (txState == ST_IDLE) begin
        ctrl.forceHigh = 1'b1;
        if (!fifoEmpty) nextState = ST_START;
      end else if (txState == ST_START) begin
        ctrl.forceLow = 1'b1;
        nextState     = ST_FIRST;
      end else if (txState == ST_FIRST) begin
        if (fifoEmpty) begin
          ctrl.forceHigh = 1'b1;
          nextState      = ST_IDLE;
        end else begin
          fifoRd        = 1'b1;
          ctrl.loadByte = 1'b1;
          nextState     = txState + STATE_W'(1);
        end
      end else if (txState < ST_STOP) begin
        ctrl.shiftBit = 1'b1;
        nextState     = txState + STATE_W'(1);
      end else if (txState == ST_STOP) begin
        ctrl.forceHigh = 1'b1;
        nextState      = txState + STATE_W'(1);
      end else begin
        nextState = ST_IDLE;  // end state (or any unused code)
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txState <= ST_IDLE;
    else       txState <= nextState;
  end
endmodule

// File: rtl/tx_shift_path.sv
module tx_shift_path
  import tick_uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txCtrl_t           ctrl,
  input  logic [DATA_W-1:0] fifoData,
  output logic              serOut
);
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      serOut   <= 1'b1;
    end else if (ctrl.loadByte) begin
      serOut   <= fifoData[0];
      shiftReg <= {1'b0, fifoData[DATA_W-1:1]};
    end else if (ctrl.shiftBit) begin
      serOut   <= shiftReg[0];
      shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
    end else if (ctrl.forceLow) begin
      serOut <= 1'b0;
    end else if (ctrl.forceHigh) begin
      serOut <= 1'b1;
    end
  end
endmodule

// File: rtl/tick_uart_tx.sv
module tick_uart_tx
  import tick_uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              fifoEmpty,
  input  logic [DATA_W-1:0] fifoData,
  output logic              fifoRd,
  output logic              serOut
);
  localparam int STATE_W = $clog2(DATA_W + 4);

  logic               bitStb;
  logic [STATE_W-1:0] txState;
  txCtrl_t            ctrl;

  tx_bit_divider #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_divider (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .bitStb(bitStb)
  );

  tx_frame_ctrl #(.DATA_W(DATA_W), .STATE_W(STATE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .bitStb(bitStb), .fifoEmpty(fifoEmpty),
    .fifoRd(fifoRd), .txState(txState), .ctrl(ctrl)
  );

  tx_shift_path #(.DATA_W(DATA_W)) i_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .fifoData(fifoData), .serOut(serOut)
  );
endmodule

// File: rtl/tick_uart_tx_chk.sv
module tick_uart_tx_chk #(
  parameter int DATA_W  = 8,
  parameter int STATE_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               tickEn,
  input logic               fifoEmpty,
  input logic               fifoDataLsb,
  input logic               fifoRd,
  input logic               serOut,
  input logic               bitStb,
  input logic [STATE_W-1:0] txState
);
  localparam logic [STATE_W-1:0] ST_IDLE  = '0;
  localparam logic [STATE_W-1:0] ST_START = STATE_W'(1);
  localparam logic [STATE_W-1:0] ST_END   = STATE_W'(DATA_W + 3);

  // R9
  rd_when_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> !fifoEmpty);

  // R4
  rd_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> tickEn);

  // R4
  rd_drives_lsb_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |=> (serOut == $past(fifoDataLsb)));

  // R7
  line_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(serOut));

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txState == ST_IDLE) |-> serOut);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txState == ST_START && bitStb) |=> !serOut);

  // R6
  end_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txState == ST_END) |-> serOut);

  // R6
  state_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    txState <= ST_END);
endmodule

bind tick_uart_tx tick_uart_tx_chk #(.DATA_W(DATA_W), .STATE_W(STATE_W)) i_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .fifoEmpty(fifoEmpty),
  .fifoDataLsb(fifoData[0]), .fifoRd(fifoRd), .serOut(serOut),
  .bitStb(bitStb), .txState(txState)
);

// File: tb/test_tick_uart_tx.sv
module test_tick_uart_tx;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic fifoEmpty = 1'b1;
  logic [7:0] fifoData = 8'h00;
  logic fifoRd;
  logic serOut;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tick_uart_tx #(.DATA_W(8), .TICKS_PER_BIT(TICKS)) i_tick_uart_tx (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .fifoEmpty(fifoEmpty),
    .fifoData(fifoData), .fifoRd(fifoRd), .serOut(serOut)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] q[$];
  logic hideFifo = 1'b0;
  int tickMode = 0;
  int cycleNo = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic logBuf [0:127];

  // behavioural reference: frame slot, tick phase, expected line
  int mSlot = 0;
  int mPhase = 0;
  logic mLine = 1'b1;
  logic [9:0] mFrame = 10'h3FF;
  logic expRd = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSlot = 0; mPhase = 0; mLine = 1'b1;
    end else if (tickEn) begin
      if (mPhase == TICKS - 1) begin
        mPhase = 0;
        if (mSlot == 0) begin
          mLine = 1'b1;
          mSlot = fifoEmpty ? 0 : 1;
        end else if (mSlot == 1) begin
          mLine = 1'b0;
          mSlot = 2;
        end else if (mSlot == 2) begin
          if (fifoEmpty) begin
            mLine = 1'b1; mSlot = 0;
          end else begin
            mFrame = {1'b1, q.pop_front(), 1'b0};
            mLine = mFrame[1];
            mSlot = 3;
          end
        end else if (mSlot <= 9) begin
          mLine = mFrame[mSlot - 1];
          mSlot = mSlot + 1;
        end else if (mSlot == 10) begin
          mLine = 1'b1; mSlot = 11;
        end else begin
          mSlot = 0;
        end
      end else begin
        mPhase = mPhase + 1;
      end
    end
  end

  function automatic string reqFor(int s);
    if (s == 0) return "R2";
    if (s == 1) return "R3";
    if (s <= 9) return "R5";
    return "R6";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cycleNo);
    end
  endtask

  task automatic cycleStep();
    @(negedge clk);
    cycleNo++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (tickMode)
      0: tickEn = 1'b1;
      1: tickEn = (cycleNo % 3 == 0);
      2: tickEn = lfsr[0];
      default: tickEn = 1'b0;
    endcase
    fifoEmpty = hideFifo || (q.size() == 0);
    fifoData = (q.size() != 0) ? q[0] : 8'h00;
    expRd = rstN && tickEn && (mPhase == TICKS - 1) && (mSlot == 2) && !fifoEmpty;
    #1;
    check(serOut === mLine, reqFor(mSlot), "serOut", int'(serOut), int'(mLine));
    check(fifoRd === expRd, "R4", "fifoRd", int'(fifoRd), int'(expRd));
    check(!(fifoRd && fifoEmpty), "R9", "fifoRd while empty", int'(fifoRd), 0);
  endtask

  task automatic drain();
    int guard = 0;
    while (!(q.size() == 0 && mSlot == 0 && !hideFifo) && guard < 4000) begin
      cycleStep(); guard++;
    end
    repeat (3 * TICKS) cycleStep();
  endtask

  task automatic pairTest(logic [7:0] b0, logic [7:0] b1);
    int a = -1;
    logic [9:0] f0, f1;
    f0 = {1'b1, b0, 1'b0};
    f1 = {1'b1, b1, 1'b0};
    tickMode = 0;
    q.push_back(b0); q.push_back(b1);
    for (int i = 0; i < 128; i++) begin
      cycleStep();
      logBuf[i] = serOut;
      if (a < 0 && serOut == 1'b0) a = i;
    end
    check(a > 0 && a < 40, "R2", "start found", a, 1);
    if (a > 0 && a < 40) begin
      check(logBuf[a-1] == 1'b1 && logBuf[a+2] == 1'b0 && logBuf[a+3] == b0[0],
            "R1", "start bit lasts 3 ticks", int'(logBuf[a+2]), 0);
      for (int i = 0; i < 10; i++)
        check(logBuf[a + 3*i + 1] == f0[i], (i == 0) ? "R3" : (i == 9) ? "R6" : "R5",
              "frame0 bit", int'(logBuf[a + 3*i + 1]), int'(f0[i]));
      for (int i = 30; i < 36; i++)
        check(logBuf[a + i] == 1'b1, "R6", "end/idle gap high", int'(logBuf[a + i]), 1);
      check(logBuf[a + 36] == 1'b0, "R6", "next start 12 bits later", int'(logBuf[a + 36]), 0);
      for (int i = 0; i < 10; i++)
        check(logBuf[a + 36 + 3*i + 1] == f1[i], (i == 0) ? "R3" : (i == 9) ? "R6" : "R5",
              "frame1 bit", int'(logBuf[a + 36 + 3*i + 1]), int'(f1[i]));
    end
    drain();
  endtask

  initial begin
    logic held;
    int guard;
    rstN = 1'b0;
    tickMode = 0;
    q.push_back(8'h5A);
    repeat (4) cycleStep();
    check(serOut === 1'b1, "R8", "serOut in reset", int'(serOut), 1);
    check(fifoRd === 1'b0, "R8", "fifoRd in reset", int'(fifoRd), 0);
    rstN = 1'b1;
    drain();

    pairTest(8'hA5, 8'h3C);

    tickMode = 1;
    q.push_back(8'h81); q.push_back(8'h7E);
    drain();

    tickMode = 2;
    q.push_back(8'h00); q.push_back(8'hFF); q.push_back(8'h55); q.push_back(8'hC3);
    drain();

    // R4: FIFO empties between the start decision and the data-bit-0 slot
    tickMode = 0;
    q.push_back(8'h96);
    guard = 0;
    while (serOut !== 1'b0 && guard < 100) begin cycleStep(); guard++; end
    hideFifo = 1'b1;
    repeat (3) cycleStep();
    check(serOut === 1'b1, "R4", "abort returns line high", int'(serOut), 1);
    check(q.size() == 1, "R4", "no byte consumed on abort", q.size(), 1);
    repeat (6) cycleStep();
    hideFifo = 1'b0;
    drain();
    check(q.size() == 0, "R4", "byte sent after abort", q.size(), 0);

    // R7: ticks stall in mid-frame
    tickMode = 0;
    q.push_back(8'hC5);
    repeat (10) cycleStep();
    tickMode = 3;
    cycleStep();
    held = serOut;
    for (int i = 0; i < 20; i++) begin
      cycleStep();
      check(serOut === held, "R7", "line frozen without ticks", int'(serOut), int'(held));
    end
    tickMode = 0;
    drain();

    // R8: reset in the middle of a frame
    q.push_back(8'h0F);
    repeat (8) cycleStep();
    rstN = 1'b0;
    repeat (2) cycleStep();
    check(serOut === 1'b1, "R8", "serOut after mid-frame reset", int'(serOut), 1);
    check(fifoRd === 1'b0, "R8", "fifoRd after mid-frame reset", int'(fifoRd), 0);
    rstN = 1'b1;
    drain();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cycleNo);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule